// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block serialises characters onto a single idle-high line. Software-side logic hands a character to a one-entry holding register through a valid/ready port; whenever transmission is enabled and that register holds a character, the character moves into a shift register and is sent as a frame. The frame has a low start bit, 7, 8 or 9 character bits sent least significant bit first, an optional odd or even parity bit, and one or two high stop bits. Because the holding register is refilled while the shift register is still sending, consecutive characters leave the line with no idle time between them.

Bit timing comes from an internal divider. It produces an oversampling tick every `baud_div + 1` clocks, and each bit lasts 16 ticks. The divider restarts whenever a frame is loaded, so every bit is exactly `16 * (baud_div + 1)` clocks long. A single select input sets when the interrupt pulse is raised: either when the holding register is handed to the shift register, or when the last stop bit has left the line. The format inputs are sampled when a character is loaded and must stay stable while the monitor of the line expects that format.

Back-pressure on the write port: `wr_ready` is high exactly when the holding register is empty. A transfer happens on a rising clock edge where `wr_valid` and `wr_ready` are both high. While `wr_ready` is low, the sender holds `wr_valid` and `wr_data`. Nothing is lost and nothing is overwritten.

Top module: `uart_tx_dbuf`

## Requirements
- R1: After reset, `txd` is 1, `buf_empty` and `wr_ready` are 1, `tx_done` is 1 and `irq` is 0.
- R2: A loaded frame is sent as follows. First a 0 start bit. Then the character bits, LSB first; the count is set by `char_len` (code 0 = 7, 1 = 8, 2 or 3 = 9). Then a parity bit if `par_en` is 1. Then 1 stop bit, or 2 if `two_stop` is 1; stop bits are 1. The format is sampled at load, and the line is 1 whenever no frame is being sent.
- R3: The parity bit is computed over the configured character bits only. With `par_odd` = 1 the character bits plus the parity bit hold an odd number of ones; with `par_odd` = 0 they hold an even number. Bits of `wr_data` above the configured length have no effect on the line.
- R4: Every bit on the line lasts exactly 16 * (`baud_div` + 1) clock cycles.
- R5: A character is moved into the shift register only while `tx_en` is 1 and the holding register is full. While `tx_en` is 0, a written character stays held and the line stays idle.
- R6: `wr_ready` equals `buf_empty`. An accepted write makes `buf_empty` 0 from the next cycle. A load makes `buf_empty` 1 from the next cycle, in the same cycle the start bit appears.
- R7: A character that is waiting when a frame ends is loaded on the edge that ends the last stop bit, so its start bit follows with no idle gap.
- R8: With `irq_on_done` = 0, `irq` is a one-cycle pulse that goes high in the same cycle the start bit appears on `txd`.
- R9: With `irq_on_done` = 1, `irq` is a one-cycle pulse that goes high in the cycle right after the last stop bit ends, which is frame length times the bit period after the start bit appeared.
- R10: Clearing `tx_en` during a frame lets that frame complete. A character waiting in the holding register is not sent until `tx_en` returns to 1.
- R11: `tx_done` is 1 exactly when no frame is on the line and the holding register is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_div | input | 8 | Divider value n; oversampling tick every n+1 clocks |
| tx_en | input | 1 | Allows characters to be loaded into the shift register |
| char_len | input | 2 | Character length code: 0 = 7, 1 = 8, 2/3 = 9 bits |
| par_en | input | 1 | Appends a parity bit |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| two_stop | input | 1 | 1 = two stop bits, 0 = one |
| irq_on_done | input | 1 | Interrupt source: 0 = at load, 1 = at end of frame |
| wr_valid | input | 1 | Write port valid |
| wr_ready | output | 1 | Write port ready (holding register empty) |
| wr_data | input | 9 | Character to send, LSB first |
| txd | output | 1 | Serial line, idle high |
| buf_empty | output | 1 | Holding register empty |
| tx_done | output | 1 | Line idle and holding register empty |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
On every cycle, the assertions check the following. A load happens only with transmit enabled and a full holding register. The line is high whenever the shift register is idle. A full holding register keeps its character until a load. A load empties the holding register. The interrupt never lasts more than one cycle. The divider never ticks on two cycles in a row when n > 0. The exact bit sequence of a frame cannot be shown by these properties, and neither can parity over the selected length, the measured bit period, the gap-free hand-off between frames, or where the interrupt falls relative to the start and the end of a frame. The bench's scoreboard and its timed scenarios cover those.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int OVS      = 16;
  localparam int CHAR_MAX = 9;
  localparam int FRAME_W  = 1 + CHAR_MAX + 1 + 2;
  localparam int LEN_W    = $clog2(FRAME_W + 1);
  localparam int SUB_W    = $clog2(OVS);

  typedef struct packed {
    logic [1:0] char_len;
    logic       par_en;
    logic       par_odd;
    logic       two_stop;
  } fmt_t;

  function automatic int unsigned char_count(logic [1:0] code);
    case (code)
      2'd0:    return 7;
      2'd1:    return 8;
      default: return 9;
    endcase
  endfunction

  function automatic logic [FRAME_W-1:0] build_frame(logic [CHAR_MAX-1:0] d, fmt_t f);
    logic [FRAME_W-1:0] v;
    logic               p;
    int unsigned        n;
    n = char_count(f.char_len);
    v = '1;
    v[0] = 1'b0;
    p = f.par_odd;
    for (int i = 0; i < CHAR_MAX; i++) begin
      if (i < n) begin
        v[1+i] = d[i];
        p      = p ^ d[i];
      end
    end
    for (int j = 1; j < FRAME_W; j++) begin
      if (f.par_en && (j == n + 1)) v[j] = p;
    end
    return v;
  endfunction

  function automatic logic [LEN_W-1:0] frame_len(fmt_t f);
    int unsigned l;
    l = 2 + char_count(f.char_len) + (f.par_en ? 1 : 0) + (f.two_stop ? 1 : 0);
    return LEN_W'(l);
  endfunction
endpackage

// File: rtl/uart_tx_baud.sv
module uart_tx_baud #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic             clr,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = (cnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clr && div != '0 && $stable(div)) |=> !tick); // R4
endmodule

// File: rtl/uart_tx_holdreg.sv
module uart_tx_holdreg #(
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  input  logic          take,
  output logic          full,
  output logic [DW-1:0] data
);
  logic accept;
  assign accept = wr_valid && !full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else if (accept) begin
      full <= 1'b1;
      data <= wr_data;
    end else if (take) begin
      full <= 1'b0;
    end
  end

  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !take) |=> (full && $stable(data))); // R6
endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
  import uart_tx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                tx_en,
  input  logic                buf_full,
  input  logic [CHAR_MAX-1:0] buf_data,
  input  fmt_t                fmt,
  output logic                load,
  output logic                frame_end,
  output logic                busy,
  output logic                txd
);
  logic [FRAME_W-1:0] shreg;
  logic [LEN_W-1:0]   len;
  logic [LEN_W-1:0]   bit_idx;
  logic [SUB_W-1:0]   sub;
  logic               bit_end;

  assign bit_end   = busy && tick && (sub == SUB_W'(OVS - 1));
  assign frame_end = bit_end && (bit_idx == len - 1'b1);
  assign load      = tx_en && buf_full && (!busy || frame_end);
  assign txd       = shreg[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '1;
      len     <= '0;
      bit_idx <= '0;
      sub     <= '0;
      busy    <= 1'b0;
    end else if (load) begin
      shreg   <= build_frame(buf_data, fmt);
      len     <= frame_len(fmt);
      bit_idx <= '0;
      sub     <= '0;
      busy    <= 1'b1;
    end else if (busy && tick) begin
      if (bit_end) begin
        sub <= '0;
        if (frame_end) begin
          busy  <= 1'b0;
          shreg <= '1;
        end else begin
          shreg   <= {1'b1, shreg[FRAME_W-1:1]};
          bit_idx <= bit_idx + 1'b1;
        end
      end else begin
        sub <= sub + 1'b1;
      end
    end
  end

  AST_LOAD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (tx_en && buf_full)); // R5
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd); // R2
endmodule

// File: rtl/uart_tx_dbuf.sv
module uart_tx_dbuf
  import uart_tx_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DIV_W-1:0]    baud_div,
  input  logic                tx_en,
  input  logic [1:0]          char_len,
  input  logic                par_en,
  input  logic                par_odd,
  input  logic                two_stop,
  input  logic                irq_on_done,
  input  logic                wr_valid,
  output logic                wr_ready,
  input  logic [CHAR_MAX-1:0] wr_data,
  output logic                txd,
  output logic                buf_empty,
  output logic                tx_done,
  output logic                irq
);
  logic                tick;
  logic                load;
  logic                frame_end;
  logic                busy;
  logic                full;
  logic [CHAR_MAX-1:0] held;
  fmt_t                fmt;

  assign fmt = '{char_len: char_len, par_en: par_en, par_odd: par_odd, two_stop: two_stop};

  uart_tx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .div(baud_div), .clr(load), .tick(tick)
  );

  uart_tx_holdreg #(.DW(CHAR_MAX)) u_hold (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .take(load), .full(full), .data(held)
  );

  uart_tx_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .tick(tick), .tx_en(tx_en), .buf_full(full),
    .buf_data(held), .fmt(fmt), .load(load), .frame_end(frame_end),
    .busy(busy), .txd(txd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_on_done ? frame_end : load;
  end

  assign buf_empty = !full;
  assign wr_ready  = !full;
  assign tx_done   = !busy && !full;

  AST_LOAD_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> buf_empty); // R6
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R8
endmodule

// File: tb/uart_tx_dbuf_tb.sv
module uart_tx_dbuf_tb;
  typedef struct packed {
    logic [8:0] d;
    logic [1:0] cl;
    logic       pe;
    logic       po;
    logic       ts;
  } item_t;

  logic       clk = 0;
  logic       rst_n = 0;
  logic [7:0] baud_div = 0;
  logic       tx_en = 0;
  logic [1:0] char_len = 2'd1;
  logic       par_en = 0, par_odd = 0, two_stop = 0, irq_on_done = 0;
  logic       wr_valid = 0;
  logic [8:0] wr_data = 0;
  logic       wr_ready, txd, buf_empty, tx_done, irq;

  int checks = 0, errors = 0, frames = 0, cyc = 0;
  item_t exp_q[$];
  int    start_log[$];
  int    irq_log[$];

  uart_tx_dbuf u_dut (
    .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .tx_en(tx_en),
    .char_len(char_len), .par_en(par_en), .par_odd(par_odd), .two_stop(two_stop),
    .irq_on_done(irq_on_done), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .txd(txd), .buf_empty(buf_empty), .tx_done(tx_done), .irq(irq)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int nchar(logic [1:0] cl);
    return (cl == 2'd0) ? 7 : (cl == 2'd1) ? 8 : 9;
  endfunction

  function automatic int flen(item_t it);
    return 2 + nchar(it.cl) + int'(it.pe) + int'(it.ts);
  endfunction

  function automatic logic fbit(item_t it, int k);
    int   n;
    logic p;
    n = nchar(it.cl);
    if (k == 0) return 1'b0;
    if (k <= n) return it.d[k-1];
    if (k == n + 1 && it.pe) begin
      p = it.po;
      for (int i = 0; i < n; i++) p = p ^ it.d[i];
      return p;
    end
    return 1'b1;
  endfunction

  task automatic push(input logic [8:0] d);
    item_t it;
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    wr_valid = 1; wr_data = d;
    it = '{d: d, cl: char_len, pe: par_en, po: par_odd, ts: two_stop};
    @(posedge clk);
    exp_q.push_back(it);
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic wait_idle();
    int n = 0;
    @(negedge clk);
    while (!(tx_done && exp_q.size() == 0) && n < 20000) begin
      @(negedge clk); n++;
    end
    repeat (4) @(negedge clk);
  endtask

  // Scoreboard monitor: pops the expected frame and checks each bit at its centre.
  initial begin
    item_t it;
    int    p, l;
    forever begin
      @(negedge clk);
      if (rst_n && txd == 1'b0) begin
        start_log.push_back(cyc);
        p = 16 * (int'(baud_div) + 1);
        repeat (p/2 - 1) @(negedge clk);
        if (exp_q.size() == 0) begin
          check(0, "R2 unexpected frame", 1, 0);
          while (txd == 1'b0) @(negedge clk);
        end else begin
          it = exp_q.pop_front();
          l = flen(it);
          for (int k = 0; k < l; k++) begin
            if (k > 0) repeat (p) @(negedge clk);
            check(txd == fbit(it, k),
                  (it.pe && k == nchar(it.cl) + 1) ? "R3 parity bit" : "R2 frame bit",
                  int'(txd), int'(fbit(it, k)));
          end
          frames++;
        end
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && irq) irq_log.push_back(cyc);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int f0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(txd == 1, "R1 txd", int'(txd), 1);
    check(buf_empty == 1 && wr_ready == 1, "R1 buf_empty", int'(buf_empty), 1);
    check(tx_done == 1, "R1 R11 tx_done", int'(tx_done), 1);
    check(irq == 0, "R1 irq", int'(irq), 0);

    // R5/R6: write with transmit disabled is held, line idle
    f0 = frames;
    push(9'h0A5);
    check(buf_empty == 0 && wr_ready == 0, "R6 empty clears", int'(buf_empty), 0);
    check(tx_done == 0, "R11 tx_done with held char", int'(tx_done), 0);
    repeat (100) @(negedge clk);
    check(start_log.size() == 0 && txd == 1, "R5 no start while disabled", start_log.size(), 0);
    check(buf_empty == 0, "R5 data held", int'(buf_empty), 0);
    tx_en = 1;
    @(negedge clk);
    check(buf_empty == 1 && txd == 0, "R6 empty sets at load", int'(buf_empty), 1);
    check(irq == 1, "R8 irq with start bit", int'(irq), 1);
    wait_idle();
    check(frames == f0 + 1, "R2 frame count", frames, f0 + 1);
    check(tx_done == 1, "R11 tx_done after frame", int'(tx_done), 1);
    check(irq_log.size() == 1 && irq_log[0] == start_log[0], "R8 irq at load",
          irq_log.size() > 0 ? irq_log[0] : -1, start_log[0]);

    // R3: 7 bits, even parity, two stops, upper bits set
    char_len = 2'd0; par_en = 1; par_odd = 0; two_stop = 1;
    push(9'h1C3);
    wait_idle();
    par_odd = 1; push(9'h080);
    wait_idle();

    // R4/R9: 9 bits, odd parity, divider 2, interrupt at end of frame
    char_len = 2'd2; par_odd = 1; two_stop = 0; baud_div = 8'd2; irq_on_done = 1;
    start_log.delete(); irq_log.delete();
    push(9'h13B);
    wait_idle();
    check(irq_log.size() == 1, "R9 one irq", irq_log.size(), 1);
    check(irq_log.size() == 1 && irq_log[0] - start_log[0] == 12 * 48,
          "R4 R9 frame duration", irq_log.size() > 0 ? irq_log[0] - start_log[0] : -1, 12 * 48);

    // R7: back-to-back 8N1 at divider 0
    char_len = 2'd1; par_en = 0; two_stop = 0; baud_div = 0; irq_on_done = 0;
    start_log.delete(); irq_log.delete();
    push(9'h03C);
    push(9'h0F0);
    wait_idle();
    check(start_log.size() == 2 && start_log[1] - start_log[0] == 10 * 16, "R7 no gap",
          start_log.size() == 2 ? start_log[1] - start_log[0] : -1, 160);
    check(irq_log.size() == 2, "R8 irq per load", irq_log.size(), 2);

    // R10: disable mid-frame
    f0 = frames;
    push(9'h055);
    push(9'h0AA);
    repeat (40) @(negedge clk);
    tx_en = 0;
    repeat (400) @(negedge clk);
    check(frames == f0 + 1, "R10 current frame finished", frames, f0 + 1);
    check(buf_empty == 0 && txd == 1, "R10 queued char held", int'(buf_empty), 0);
    check(tx_done == 0, "R11 tx_done with queued char", int'(tx_done), 0);
    tx_en = 1;
    wait_idle();
    check(frames == f0 + 2, "R10 queued char sent after enable", frames, f0 + 2);
    check(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule